// File: doc/BRIEF.md
# Store Merging Line Buffer

This block sits between a data cache that does not allocate on write misses and the next level of memory. It keeps a few entries, each one 64-byte line with one valid bit per byte. A store that misses the cache, or a dirty line that the cache evicts, goes into this buffer. When a later store falls in a line that an entry already holds, it merges into that entry rather than taking a new one. Entries go back to the next level one at a time, oldest first. A write-back may only start in a cycle where the next level is not serving a read.

A lookup port is checked in parallel with each cache miss. If the buffer holds every byte of the requested line, the line can be supplied straight from the buffer. If it holds only some bytes, the block reports a partial hit along with the byte mask. The requester then merges those bytes over the data that comes back from the next level.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the buffer is empty. `wr_valid` is 0, `st_ready` is 1 and every lookup misses.
- R2: A store to a line held by no unlocked entry takes a free entry, filled in arrival order. Its byte-valid bits equal `st_mask`, where bit i covers byte i, and byte i is carried on data bits 8i+7:8i.
- R3: A store to a line already held by an unlocked entry merges into that entry and takes no new one. The bytes whose mask bits are set are replaced, and those mask bits are ORed into the entry's byte-valid bits.
- R4: An eviction (`st_evict`=1) carries a whole line. If it misses, it takes an entry with all 64 byte-valid bits set. If it matches an entry, it fills only the bytes that entry does not yet hold, and the entry becomes fully valid.
- R5: A lookup is combinational and reflects the state before any store accepted in the same cycle. `lk_full` is 1 only when the held bytes for the line cover all 64 bytes, and `lk_data` then gives the line.
- R6: When only some bytes are held, `lk_partial` is 1, `lk_full` is 0 and `lk_mask`/`lk_data` give the held bytes. When the line is absent, both flags and `lk_mask` are 0.
- R7: A write-back starts only after a clock edge at which the buffer is not empty, no write-back is in progress and `nl_read_busy` is 0. `wr_valid` then rises in the next cycle.
- R8: Once `wr_valid` is 1, it stays 1 with stable `wr_line`, `wr_data` and `wr_mask` until `wr_ready` is 1, even if `nl_read_busy` rises. The entry is freed at that handshake.
- R9: Entries are written back in the order their lines were first allocated.
- R10: While an entry is being written back it is locked. A store to its line opens a new entry, and a lookup combines both entries with the newer bytes taking priority.
- R11: When every entry is occupied and the store's line is held by no unlocked entry, `st_ready` is 0 and the store has no effect. `st_ready` returns to 1 in the cycle after an entry is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store or eviction offered |
| st_ready | output | 1 | Buffer can take the offered store |
| st_evict | input | 1 | 1: whole dirty-line eviction, 0: byte store |
| st_line | input | ADDR_W-6 | Line address of the store |
| st_data | input | 512 | Store data, byte i at bits 8i+7:8i |
| st_mask | input | 64 | Bytes written by the store |
| lk_valid | input | 1 | Lookup request from a cache miss |
| lk_line | input | ADDR_W-6 | Line address looked up |
| lk_full | output | 1 | Complete line held, miss can be served |
| lk_partial | output | 1 | Only part of the line held |
| lk_data | output | 512 | Held bytes, newest value per byte |
| lk_mask | output | 64 | Which bytes are held |
| nl_read_busy | input | 1 | Next level is serving a read |
| wr_valid | output | 1 | Write-back offered to the next level |
| wr_ready | input | 1 | Next level takes the write-back |
| wr_line | output | ADDR_W-6 | Line address written back |
| wr_data | output | 512 | Line data written back |
| wr_mask | output | 64 | Valid bytes of the write-back |

## Verification
A corrupted byte-valid bit shows up at the lookup port in the same cycle, as a full hit turning partial or the reverse. Any damaged data byte shows there too. A wrong head or tail pointer, or a lock that never releases, shows up as a write-back arriving out of order, or as `st_ready` staying low one cycle after a handshake. A drain that ignores the read-busy input raises `wr_valid` one cycle after the busy edge instead of holding it low. The single-byte sweep walks the byte-valid bits one at a time, so a bad merge or OR of the mask is caught at the first byte it affects.

// File: rtl/smb_pkg.sv
package smb_pkg;
   localparam int unsigned LINE_BYTES = 64;
   localparam int unsigned OFS_W      = $clog2(LINE_BYTES);
   localparam int unsigned LINE_BITS  = LINE_BYTES * 8;

   typedef logic [LINE_BYTES-1:0] byte_mask_t;
   typedef logic [LINE_BITS-1:0]  line_data_t;

   // widen a byte mask to a bit mask over the line
   function automatic line_data_t bytes_to_bits(byte_mask_t m);
      line_data_t r;
      for (int b = 0; b < int'(LINE_BYTES); b++) begin
         r[b*8 +: 8] = {8{m[b]}};
      end
      return r;
   endfunction
endpackage

// File: rtl/smb_slot.sv
module smb_slot
   import smb_pkg::*;
#(
   parameter int unsigned LINE_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              merge_i,
   input  logic              clear_i,
   input  logic              evict_i,
   input  logic [LINE_W-1:0] line_i,
   input  line_data_t        data_i,
   input  byte_mask_t        mask_i,
   output logic              valid_o,
   output logic [LINE_W-1:0] line_o,
   output line_data_t        data_o,
   output byte_mask_t        mask_o
);
   line_data_t new_bits;
   line_data_t old_bits;

   assign new_bits = bytes_to_bits(mask_i);
   assign old_bits = bytes_to_bits(mask_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         line_o  <= '0;
         data_o  <= '0;
         mask_o  <= '0;
      end else if (clear_i) begin
         valid_o <= 1'b0;
         mask_o  <= '0;
      end else if (alloc_i) begin
         valid_o <= 1'b1;
         line_o  <= line_i;
         if (evict_i) begin
            data_o <= data_i;
            mask_o <= '1;
         end else begin
            data_o <= data_i & new_bits;
            mask_o <= mask_i;
         end
      end else if (merge_i) begin
         if (evict_i) begin
            // newer store bytes win over the evicted copy
            data_o <= (data_o & old_bits) | (data_i & ~old_bits);
            mask_o <= '1;
         end else begin
            data_o <= (data_o & ~new_bits) | (data_i & new_bits);
            mask_o <= mask_o | mask_i;
         end
      end
   end

   a_r2_alloc_free_slot : assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !valid_o);
   a_r3_merge_live_slot : assert property (@(posedge clk) disable iff (!rst_n)
      merge_i |-> valid_o);
   a_r3_mask_grows : assert property (@(posedge clk) disable iff (!rst_n)
      (merge_i && !evict_i) |=> (((mask_o & $past(mask_i)) == $past(mask_i)) &&
                                 ((mask_o & $past(mask_o)) == $past(mask_o))));
   a_r4_evict_completes : assert property (@(posedge clk) disable iff (!rst_n)
      (merge_i && evict_i) |=> (&mask_o));
endmodule

// File: rtl/smb_order.sv
module smb_order #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             busy_i,
   output logic [PTR_W-1:0] head_o,
   output logic [PTR_W-1:0] tail_o,
   output logic             full_o,
   output logic             drain_o
);
   logic [CNT_W-1:0] count_q;

   assign full_o = (count_q == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_o  <= '0;
         tail_o  <= '0;
         count_q <= '0;
         drain_o <= 1'b0;
      end else begin
         if (push_i) tail_o <= tail_o + 1'b1;
         if (pop_i)  head_o <= head_o + 1'b1;
         count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
         if (drain_o) begin
            if (pop_i) drain_o <= 1'b0;
         end else if ((count_q != '0) && !busy_i) begin
            drain_o <= 1'b1;
         end
      end
   end

   a_r11_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && full_o));
   a_r11_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
   a_r7_start_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drain_o) |-> $past(!busy_i));
   a_r8_pop_in_drain : assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> drain_o);
   a_r8_drain_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (drain_o && !pop_i) |=> drain_o);
endmodule

// File: rtl/smb_lookup.sv
module smb_lookup
   import smb_pkg::*;
#(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned LINE_W = 30,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]             valid_i,
   input  logic [DEPTH-1:0][LINE_W-1:0] lines_i,
   input  line_data_t [DEPTH-1:0]       datas_i,
   input  byte_mask_t [DEPTH-1:0]       masks_i,
   input  logic [PTR_W-1:0]             head_i,
   input  logic [LINE_W-1:0]            key_i,
   output line_data_t                   data_o,
   output byte_mask_t                   mask_o
);
   // walk from oldest to newest so later entries override earlier bytes
   always_comb begin
      data_o = '0;
      mask_o = '0;
      for (int k = 0; k < int'(DEPTH); k++) begin
         logic [PTR_W-1:0] idx;
         line_data_t       bits;
         idx  = head_i + PTR_W'(k);
         bits = bytes_to_bits(masks_i[idx]);
         if (valid_i[idx] && (lines_i[idx] == key_i)) begin
            data_o = (data_o & ~bits) | (datas_i[idx] & bits);
            mask_o = mask_o | masks_i[idx];
         end
      end
   end
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer
   import smb_pkg::*;
#(
   parameter int unsigned ADDR_W = 36,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned LINE_W = ADDR_W - OFS_W,
   localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic              st_evict,
   input  logic [LINE_W-1:0] st_line,
   input  logic [511:0]      st_data,
   input  logic [63:0]       st_mask,
   input  logic              lk_valid,
   input  logic [LINE_W-1:0] lk_line,
   output logic              lk_full,
   output logic              lk_partial,
   output logic [511:0]      lk_data,
   output logic [63:0]       lk_mask,
   input  logic              nl_read_busy,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [LINE_W-1:0] wr_line,
   output logic [511:0]      wr_data,
   output logic [63:0]       wr_mask
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("store_merge_buffer: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("store_merge_buffer: ADDR_W must exceed the line offset width");
   end

   logic [DEPTH-1:0]             slot_valid;
   logic [DEPTH-1:0][LINE_W-1:0] slot_line;
   line_data_t [DEPTH-1:0]       slot_data;
   byte_mask_t [DEPTH-1:0]       slot_mask;
   logic [DEPTH-1:0]             hit_vec;
   logic [DEPTH-1:0]             merge_vec;
   logic [DEPTH-1:0]             alloc_vec;
   logic [DEPTH-1:0]             clear_vec;
   logic [PTR_W-1:0]             head, tail;
   logic                         full, draining, hit_any, accept, push, pop;
   line_data_t                   fwd_data;
   byte_mask_t                   fwd_mask;

   assign hit_any  = |hit_vec;
   assign st_ready = hit_any || !full;
   assign accept   = st_valid && st_ready;
   assign push     = accept && !hit_any;
   assign pop      = wr_valid && wr_ready;

   for (genvar i = 0; i < int'(DEPTH); i++) begin : g_slot
      logic locked;
      assign locked       = draining && (head == PTR_W'(i));
      assign hit_vec[i]   = slot_valid[i] && (slot_line[i] == st_line) && !locked;
      assign merge_vec[i] = accept && hit_vec[i];
      assign alloc_vec[i] = push && (tail == PTR_W'(i));
      assign clear_vec[i] = pop && (head == PTR_W'(i));

      smb_slot #(.LINE_W(LINE_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .alloc_i (alloc_vec[i]),
         .merge_i (merge_vec[i]),
         .clear_i (clear_vec[i]),
         .evict_i (st_evict),
         .line_i  (st_line),
         .data_i  (st_data),
         .mask_i  (st_mask),
         .valid_o (slot_valid[i]),
         .line_o  (slot_line[i]),
         .data_o  (slot_data[i]),
         .mask_o  (slot_mask[i])
      );
   end

   smb_order #(.DEPTH(DEPTH)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .pop_i   (pop),
      .busy_i  (nl_read_busy),
      .head_o  (head),
      .tail_o  (tail),
      .full_o  (full),
      .drain_o (draining)
   );

   smb_lookup #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_lookup (
      .valid_i (slot_valid),
      .lines_i (slot_line),
      .datas_i (slot_data),
      .masks_i (slot_mask),
      .head_i  (head),
      .key_i   (lk_line),
      .data_o  (fwd_data),
      .mask_o  (fwd_mask)
   );

   assign lk_mask    = lk_valid ? fwd_mask : '0;
   assign lk_data    = lk_valid ? fwd_data : '0;
   assign lk_full    = lk_valid && (&fwd_mask);
   assign lk_partial = lk_valid && (|fwd_mask) && !(&fwd_mask);

   assign wr_valid = draining;
   assign wr_line  = slot_line[head];
   assign wr_data  = slot_data[head];
   assign wr_mask  = slot_mask[head];

   a_r3_single_owner : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   a_r6_flags_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_full, lk_partial}));
   a_r8_payload_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_line) &&
                                   $stable(wr_data) && $stable(wr_mask)));
   a_r9_head_occupied : assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> slot_valid[head]);
   a_r11_refuse_when_full : assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_ready) |-> full);
endmodule

// File: tb/store_merge_buffer_bench.sv
module store_merge_buffer_bench;
   localparam int ADDR_W = 36;
   localparam int LINE_W = ADDR_W - 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              st_valid = 1'b0, st_evict = 1'b0, lk_valid = 1'b0;
   logic [LINE_W-1:0] st_line = '0, lk_line = '0;
   logic [511:0]      st_data = '0;
   logic [63:0]       st_mask = '0;
   logic              nl_read_busy = 1'b1, wr_ready = 1'b0;
   logic              st_ready, lk_full, lk_partial, wr_valid;
   logic [511:0]      lk_data, wr_data;
   logic [63:0]       lk_mask, wr_mask;
   logic [LINE_W-1:0] wr_line;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   store_merge_buffer #(.ADDR_W(ADDR_W), .DEPTH(4)) u_store_merge_buffer (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_evict(st_evict),
      .st_line(st_line), .st_data(st_data), .st_mask(st_mask),
      .lk_valid(lk_valid), .lk_line(lk_line), .lk_full(lk_full),
      .lk_partial(lk_partial), .lk_data(lk_data), .lk_mask(lk_mask),
      .nl_read_busy(nl_read_busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_line(wr_line), .wr_data(wr_data), .wr_mask(wr_mask)
   );

   function automatic logic [511:0] mk(int line, int tag);
      logic [511:0] d;
      for (int b = 0; b < 64; b++) d[b*8 +: 8] = 8'(line * 7 + b * 3 + tag * 29 + 1);
      return d;
   endfunction

   function automatic logic [511:0] widen(logic [63:0] m);
      logic [511:0] r;
      for (int b = 0; b < 64; b++) r[b*8 +: 8] = {8{m[b]}};
      return r;
   endfunction

   function automatic logic [511:0] blend(logic [511:0] base, logic [511:0] top, logic [63:0] m);
      return (base & ~widen(m)) | (top & widen(m));
   endfunction

   task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic store(int line, logic [511:0] d, logic [63:0] m, bit ev, bit exp_rdy, string req);
      @(negedge clk);
      st_valid = 1'b1; st_line = LINE_W'(line); st_data = d; st_mask = m; st_evict = ev;
      #1 chk(st_ready == exp_rdy, req, "st_ready", 512'(st_ready), 512'(exp_rdy));
      @(posedge clk);
      #1 st_valid = 1'b0; st_evict = 1'b0;
   endtask

   task automatic look(int line, bit ef, bit ep, logic [63:0] em, logic [511:0] ed, string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_line = LINE_W'(line);
      #1;
      chk(lk_full == ef, req, "lk_full", 512'(lk_full), 512'(ef));
      chk(lk_partial == ep, req, "lk_partial", 512'(lk_partial), 512'(ep));
      chk(lk_mask == em, req, "lk_mask", 512'(lk_mask), 512'(em));
      chk((lk_data & widen(em)) == (ed & widen(em)), req, "lk_data",
          lk_data & widen(em), ed & widen(em));
      lk_valid = 1'b0;
   endtask

   task automatic drain(int line, logic [511:0] ed, logic [63:0] em, string req);
      int n = 0;
      @(negedge clk);
      while (!wr_valid && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(wr_valid, req, "wr_valid", 512'(wr_valid), 512'(1));
      chk(wr_line == LINE_W'(line), req, "wr_line", 512'(wr_line), 512'(line));
      chk(wr_mask == em, req, "wr_mask", 512'(wr_mask), 512'(em));
      chk((wr_data & widen(em)) == (ed & widen(em)), req, "wr_data",
          wr_data & widen(em), ed & widen(em));
      wr_ready = 1'b1;
      @(posedge clk);
      #1 wr_ready = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [511:0] a_exp, b_exp, c_exp;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      st_line = LINE_W'(9);
      #1 chk(st_ready == 1'b1, "R1", "st_ready", 512'(st_ready), 512'(1));
      chk(wr_valid == 1'b0, "R1", "wr_valid", 512'(wr_valid), 512'(0));
      look(9, 0, 0, 64'h0, '0, "R1");

      // R2 allocate partial, R6 partial hit
      store(1, mk(1, 0), 64'h0000_0000_FFFF_FFFF, 0, 1, "R2");
      look(1, 0, 1, 64'h0000_0000_FFFF_FFFF, mk(1, 0), "R6");
      // R3 merge completes the line, R5 full hit
      store(1, mk(1, 1), 64'hFFFF_FFFF_0000_0000, 0, 1, "R3");
      a_exp = blend(mk(1, 0), mk(1, 1), 64'hFFFF_FFFF_0000_0000);
      look(1, 1, 0, '1, a_exp, "R5");

      // R3/R5/R6 byte-by-byte sweep on line 2
      for (int i = 0; i < 64; i++) begin
         logic [63:0] m;
         m = (64'(1) << (i + 1)) - 64'(1);
         store(2, mk(2, 5), 64'(1) << i, 0, 1, "R3");
         look(2, i == 63, i != 63, m, mk(2, 5), i == 63 ? "R5" : "R6");
      end

      // R4 eviction onto a partial entry keeps newer bytes
      store(3, mk(3, 2), {32{2'b01}}, 0, 1, "R2");
      store(3, mk(3, 3), '1, 1, 1, "R4");
      c_exp = blend(mk(3, 3), mk(3, 2), {32{2'b01}});
      look(3, 1, 0, '1, c_exp, "R4");
      // R4 eviction with no match allocates a full entry
      store(4, mk(4, 4), 64'h0, 1, 1, "R4");
      look(4, 1, 0, '1, mk(4, 4), "R4");

      // R11 full: new line refused, existing line merges
      store(5, mk(5, 0), '1, 0, 0, "R11");
      look(5, 0, 0, 64'h0, '0, "R11");
      store(2, mk(2, 6), 64'h1, 0, 1, "R11");
      b_exp = blend(mk(2, 5), mk(2, 6), 64'h1);
      look(2, 1, 0, '1, b_exp, "R3");

      // R7 no write-back while the next level reads
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         #1 chk(wr_valid == 1'b0, "R7", "wr_valid while busy", 512'(wr_valid), 512'(0));
      end
      @(negedge clk);
      nl_read_busy = 1'b0;
      #1 chk(wr_valid == 1'b0, "R7", "wr_valid same cycle", 512'(wr_valid), 512'(0));
      @(negedge clk);
      #1 chk(wr_valid == 1'b1, "R7", "wr_valid next cycle", 512'(wr_valid), 512'(1));
      nl_read_busy = 1'b1;
      // R8 hold while not accepted, even with busy
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1 chk(wr_valid && wr_line == LINE_W'(1), "R8", "held write-back",
                512'(wr_line), 512'(1));
      end
      // R10 locked head, full buffer: store to its line refused
      store(1, mk(1, 9), '1, 0, 0, "R10");
      drain(1, a_exp, '1, "R9");
      // R11 space frees the cycle after the handshake
      @(negedge clk);
      st_line = LINE_W'(5);
      #1 chk(st_ready == 1'b1, "R11", "st_ready after free", 512'(st_ready), 512'(1));
      chk(wr_valid == 1'b0, "R7", "no restart while busy", 512'(wr_valid), 512'(0));
      nl_read_busy = 1'b0;
      drain(2, b_exp, '1, "R9");
      drain(3, c_exp, '1, "R9");
      drain(4, mk(4, 4), '1, "R9");

      // R10 lock with space: store opens a new entry
      nl_read_busy = 1'b1;
      store(1, mk(1, 7), '1, 0, 1, "R2");
      @(negedge clk);
      nl_read_busy = 1'b0;
      @(negedge clk);
      nl_read_busy = 1'b1;
      #1 chk(wr_valid == 1'b1, "R7", "second drain start", 512'(wr_valid), 512'(1));
      store(1, mk(1, 8), 64'hFF, 0, 1, "R10");
      look(1, 1, 0, '1, blend(mk(1, 7), mk(1, 8), 64'hFF), "R10");
      drain(1, mk(1, 7), '1, "R10");
      nl_read_busy = 1'b0;
      drain(1, mk(1, 8), 64'hFF, "R10");
      look(1, 0, 0, 64'h0, '0, "R6");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule